// File: doc/BRIEF.md
# Four-State Snooping Coherent Cache Controller

This block is a small direct-mapped data cache whose lines are kept coherent with peer caches on a shared snooping bus. Each line carries one of four states: modified (sole copy, memory stale), exclusive (sole copy, memory current), shared (clean copies may exist elsewhere, memory current) and invalid (not present). Core loads and stores arrive on a valid/ready request port. Misses, ownership requests and dirty evictions go out as single bus transactions. Traffic from other caches is snooped and may downgrade or invalidate a line, or force its data back to memory.

The core port follows valid/ready rules. The core raises `core_valid` and holds `core_we`, `core_addr` and `core_wdata` stable until a cycle with `core_ready` high. A read's data is on `core_rdata` in that same cycle. The bus request port works the same way. `bus_req_valid` is held with a stable opcode and address until `bus_gnt`. The whole transaction (memory data, the peers' wired-OR shared answer, and the write-back data) completes in the granted cycle. Snoop responses are combinational in the cycle the snoop is presented. The arbiter never grants this cache while it is being snooped.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is invalid: `bus_req_valid`, `core_ready`, `snp_shared` and `snp_flush` are low, and a snoop to any address draws no response.
- R2: A read that hits a modified, exclusive or shared line completes with `core_ready` high and no bus request, with the line's data on `core_rdata` in that cycle.
- R3: A read miss issues a bus read (opcode 0). If `bus_shared_in` is high in the granted cycle, the line is filled as shared, otherwise as exclusive. The read completes one cycle after the grant with the filled data.
- R4: A write to a modified or exclusive line completes with no bus request and leaves the line modified.
- R5: A write to a shared line issues an upgrade (opcode 2). A write to an invalid or non-matching slot issues a read-exclusive (opcode 1). In both cases the line becomes modified before the write completes one cycle after the grant.
- R6: A snooped bus read that hits a modified line raises `snp_shared` and `snp_flush` with the line data, and the line becomes shared. On an exclusive hit only `snp_shared` is raised, and the line becomes shared. On a shared hit only `snp_shared` is raised. A miss draws no response.
- R7: A snooped read-exclusive (opcode 1) that hits a modified line raises `snp_flush` with the line data. On an exclusive or shared hit there is no flush and no shared answer. In every hit case the line becomes invalid.
- R8: A snooped upgrade (opcode 2) has exactly the effect of a snooped read-exclusive.
- R9: Before refilling a slot that holds a modified line of another address, the block issues a write-back (opcode 3) carrying the victim's address and data, and the slot becomes invalid. Exclusive or shared victims are overwritten with no write-back.
- R10: While `snp_valid` is high, `core_ready` and `bus_req_valid` are low. A pending request is re-decided afterwards against the updated state, so a pending upgrade whose line was invalidated is issued as a read-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Core request completes this cycle |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Store data |
| core_rdata | output | DATA_W | Load data, valid with handshake |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_gnt | input | 1 | Transaction granted and completed this cycle |
| bus_op | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data (memory or peer flush) |
| bus_shared_in | input | 1 | Wired-OR shared answer from peers |
| snp_valid | input | 1 | Peer transaction being snooped |
| snp_op | input | 2 | Snooped opcode, same encoding as bus_op |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds a copy (read snoops) |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_flush_data | output | DATA_W | Dirty data for memory |

## Verification
A snoop and a pending core store can fall in the same cycle. The bench first brings a line to shared. It then withholds the grant so that an upgrade request stays pending, and presents a read-exclusive snoop to that address in the same cycle. That cycle is judged by both the core handshake and the bus request being held low. The following cycle is judged by the request having turned into a read-exclusive, and a later snoop read confirms the store landed as a modified line carrying the new data.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_RDX  = 2'd1,
    OP_UPGR = 2'd2,
    OP_WB   = 2'd3
  } bus_op_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              a_idx,
  output line_st_e                      a_st,
  output logic [TAG_W-1:0]              a_tag,
  output logic [DATA_W-1:0]             a_data,
  input  logic [IDX_W-1:0]              b_idx,
  output line_st_e                      b_st,
  output logic [TAG_W-1:0]              b_tag,
  output logic [DATA_W-1:0]             b_data,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  line_st_e                      wr_st,
  input  logic                          wr_tag_en,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic                          wr_data_en,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [LINES-1:0][1:0]         st_vec
);
  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= ST_I;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (sel) begin
        st_q[g] <= wr_st;
        if (wr_tag_en)  tag_q[g]  <= wr_tag;
        if (wr_data_en) data_q[g] <= wr_data;
      end
    end
    assign st_vec[g] = st_q[g];
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             snp_valid,
  input  bus_op_e          snp_op,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             hit,
  output logic             shared,
  output logic             flush,
  output logic             upd,
  output line_st_e         nxt_st
);
  always_comb begin
    hit    = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
    shared = 1'b0;
    flush  = 1'b0;
    upd    = 1'b0;
    nxt_st = line_st;
    if (hit) begin
      upd   = 1'b1;
      flush = (line_st == ST_M);
      if (snp_op == OP_RD) begin
        shared = 1'b1;
        nxt_st = ST_S;
      end else if (snp_op == OP_RDX || snp_op == OP_UPGR) begin
        nxt_st = ST_I;
      end else begin
        upd   = 1'b0;
        flush = 1'b0;
      end
    end
  end
endmodule

// File: rtl/mesi_req_engine.sv
module mesi_req_engine
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              core_valid,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              snp_busy,
  output logic              bus_req_valid,
  input  logic              bus_gnt,
  output bus_op_e           bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  output logic              w_en,
  output line_st_e          w_st,
  output logic              w_tag_en,
  output logic              w_data_en,
  output logic [DATA_W-1:0] w_data
);
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             tag_hit;
  logic             need_bus;

  assign idx     = core_addr[IDX_W-1:0];
  assign tag     = core_addr[ADDR_W-1:IDX_W];
  assign tag_hit = (line_st != ST_I) && (line_tag == tag);

  always_comb begin
    need_bus  = 1'b1;
    bus_op    = OP_RD;
    bus_addr  = core_addr;
    bus_wdata = line_data;
    if (!tag_hit && line_st == ST_M) begin
      bus_op   = OP_WB;
      bus_addr = {line_tag, idx};
    end else if (!core_we) begin
      need_bus = !tag_hit;
    end else if (tag_hit && (line_st == ST_M || line_st == ST_E)) begin
      need_bus = 1'b0;
    end else if (tag_hit) begin
      bus_op = OP_UPGR;
    end else begin
      bus_op = OP_RDX;
    end
  end

  assign bus_req_valid = core_valid && need_bus && !snp_busy;
  assign core_ready    = core_valid && !need_bus && !snp_busy;

  always_comb begin
    w_en      = 1'b0;
    w_st      = line_st;
    w_tag_en  = 1'b0;
    w_data_en = 1'b0;
    w_data    = core_wdata;
    if (core_ready && core_we) begin
      w_en      = 1'b1;
      w_st      = ST_M;
      w_data_en = 1'b1;
    end else if (bus_req_valid && bus_gnt) begin
      w_en = 1'b1;
      unique case (bus_op)
        OP_WB:   w_st = ST_I;
        OP_UPGR: w_st = ST_M;
        OP_RDX: begin
          w_st      = ST_M;
          w_tag_en  = 1'b1;
          w_data_en = 1'b1;
          w_data    = bus_rdata;
        end
        default: begin
          w_st      = bus_shared_in ? ST_S : ST_E;
          w_tag_en  = 1'b1;
          w_data_en = 1'b1;
          w_data    = bus_rdata;
        end
      endcase
    end
  end
endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  output logic              core_ready,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req_valid,
  input  logic              bus_gnt,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_flush_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  c_idx, s_idx;
  line_st_e          c_st, s_st;
  logic [TAG_W-1:0]  c_tag, s_tag;
  logic [DATA_W-1:0] c_data, s_data;
  logic [LINES-1:0][1:0] st_vec;

  logic              s_hit, s_upd;
  line_st_e          s_nst;
  bus_op_e           op_e;

  logic              e_en, e_tag_en, e_data_en;
  line_st_e          e_st;
  logic [DATA_W-1:0] e_data;

  logic              wr_en, wr_tag_en, wr_data_en;
  logic [IDX_W-1:0]  wr_idx;
  line_st_e          wr_st;

  assign c_idx = core_addr[IDX_W-1:0];
  assign s_idx = snp_addr[IDX_W-1:0];

  mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(c_idx), .a_st(c_st), .a_tag(c_tag), .a_data(c_data),
    .b_idx(s_idx), .b_st(s_st), .b_tag(s_tag), .b_data(s_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st),
    .wr_tag_en(wr_tag_en), .wr_tag(core_addr[ADDR_W-1:IDX_W]),
    .wr_data_en(wr_data_en), .wr_data(e_data),
    .st_vec(st_vec)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid(snp_valid), .snp_op(bus_op_e'(snp_op)),
    .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_st(s_st), .line_tag(s_tag),
    .hit(s_hit), .shared(snp_shared), .flush(snp_flush),
    .upd(s_upd), .nxt_st(s_nst)
  );
  assign snp_flush_data = s_data;

  mesi_req_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_req (
    .core_valid(core_valid), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_ready(core_ready),
    .line_st(c_st), .line_tag(c_tag), .line_data(c_data),
    .snp_busy(snp_valid),
    .bus_req_valid(bus_req_valid), .bus_gnt(bus_gnt), .bus_op(op_e),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_shared_in(bus_shared_in),
    .w_en(e_en), .w_st(e_st), .w_tag_en(e_tag_en),
    .w_data_en(e_data_en), .w_data(e_data)
  );
  assign bus_op     = op_e;
  assign core_rdata = c_data;

  // snoop updates win the single write port
  always_comb begin
    if (s_upd) begin
      wr_en = 1'b1; wr_idx = s_idx; wr_st = s_nst;
      wr_tag_en = 1'b0; wr_data_en = 1'b0;
    end else begin
      wr_en = e_en; wr_idx = c_idx; wr_st = e_st;
      wr_tag_en = e_tag_en; wr_data_en = e_data_en;
    end
  end

  // R3: a granted read leaves the slot shared or exclusive per the peers' answer
  p_fill_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_gnt && op_e == OP_RD |=>
      st_vec[$past(c_idx)] == ($past(bus_shared_in) ? 2'(ST_S) : 2'(ST_E)));

  // R4: a completed store leaves its line modified
  p_store_owns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid && core_ready && core_we |=> st_vec[$past(c_idx)] == 2'(ST_M));

  // R6: a snooped read hit leaves the line shared
  p_snoop_rd_share_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_op == 2'(OP_RD) && s_hit |=> st_vec[$past(s_idx)] == 2'(ST_S));

  // R7, R8: read-exclusive or upgrade snoop hit invalidates the line
  p_snoop_inval_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && (snp_op == 2'(OP_RDX) || snp_op == 2'(OP_UPGR)) && s_hit |=>
      st_vec[$past(s_idx)] == 2'(ST_I));

  // R9: a granted write-back frees its slot
  p_evict_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_gnt && op_e == OP_WB |=> st_vec[$past(c_idx)] == 2'(ST_I));

  // R10: a snoop cycle blocks both local paths
  p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !core_ready && !bus_req_valid);
endmodule

// File: tb/tb_mesi_snoop_cache.sv
`timescale 1ns/1ps
module tb_mesi_snoop_cache;
  localparam int AW = 6;
  localparam int DW = 16;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_SNP = 2'd2, K_SNPW = 2'd3;
  localparam logic [1:0] O_RD = 2'd0, O_RDX = 2'd1, O_UPG = 2'd2, O_WB = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [5:0]  addr;
    logic [15:0] data;
    logic        sh;
    logic [1:0]  n;
    logic [1:0]  o0;
    logic [1:0]  o1;
    logic        es;
    logic        ef;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{K_RD,  6'h04, 16'h0000, 1'b0, 2'd1, O_RD,  O_RD, 1'b0, 1'b0}, // R3 miss -> E
    '{K_RD,  6'h04, 16'h0000, 1'b0, 2'd0, O_RD,  O_RD, 1'b0, 1'b0}, // R2 hit E
    '{K_WR,  6'h04, 16'hA001, 1'b0, 2'd0, O_RD,  O_RD, 1'b0, 1'b0}, // R4 E -> M
    '{K_WR,  6'h04, 16'hB002, 1'b0, 2'd0, O_RD,  O_RD, 1'b0, 1'b0}, // R4 M
    '{K_SNP, 6'h04, 16'h0000, 1'b0, 2'd0, O_RD,  O_RD, 1'b1, 1'b1}, // R6 M flush -> S
    '{K_SNP, 6'h04, 16'h0000, 1'b0, 2'd0, O_RD,  O_RD, 1'b1, 1'b0}, // R6 S stays
    '{K_WR,  6'h04, 16'hC003, 1'b0, 2'd1, O_UPG, O_RD, 1'b0, 1'b0}, // R5 S -> upgrade
    '{K_SNP, 6'h04, 16'h0000, 1'b0, 2'd0, O_RDX, O_RD, 1'b0, 1'b1}, // R7 M flush -> I
    '{K_RD,  6'h04, 16'h0000, 1'b1, 2'd1, O_RD,  O_RD, 1'b0, 1'b0}, // R3 miss -> S
    '{K_SNPW,6'h04, 16'hD004, 1'b0, 2'd0, O_UPG, O_RD, 1'b0, 1'b0}, // R8 S -> I, peer writes
    '{K_RD,  6'h04, 16'h0000, 1'b0, 2'd1, O_RD,  O_RD, 1'b0, 1'b0}, // R8 refetch new value
    '{K_SNP, 6'h04, 16'h0000, 1'b0, 2'd0, O_RDX, O_RD, 1'b0, 1'b0}, // R7 E -> I no flush
    '{K_WR,  6'h05, 16'hE005, 1'b0, 2'd1, O_RDX, O_RD, 1'b0, 1'b0}, // R5 I -> read-exclusive
    '{K_RD,  6'h05, 16'h0000, 1'b0, 2'd0, O_RD,  O_RD, 1'b0, 1'b0}, // R2 hit M
    '{K_SNP, 6'h09, 16'h0000, 1'b0, 2'd0, O_RD,  O_RD, 1'b0, 1'b0}, // R6 tag miss ignored
    '{K_RD,  6'h09, 16'h0000, 1'b0, 2'd2, O_WB,  O_RD, 1'b0, 1'b0}, // R9 dirty victim
    '{K_RD,  6'h05, 16'h0000, 1'b0, 2'd1, O_RD,  O_RD, 1'b0, 1'b0}, // R9 clean victim silent
    '{K_SNP, 6'h05, 16'h0000, 1'b0, 2'd0, O_RD,  O_RD, 1'b1, 1'b0}, // R6 E -> S
    '{K_WR,  6'h05, 16'hF006, 1'b0, 2'd1, O_UPG, O_RD, 1'b0, 1'b0}, // R5 upgrade again
    '{K_SNP, 6'h02, 16'h0000, 1'b0, 2'd0, O_RD,  O_RD, 1'b0, 1'b0}  // R6 invalid slot ignored
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_valid = 1'b0, core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic core_ready;
  logic [DW-1:0] core_rdata;
  logic bus_req_valid, bus_gnt;
  logic [1:0] bus_op;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_shared_in = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_op = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_flush;
  logic [DW-1:0] snp_flush_data;
  logic gnt_en = 1'b1;

  logic [DW-1:0] mem  [64];
  logic [DW-1:0] gold [64];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign bus_gnt   = gnt_en && bus_req_valid;
  assign bus_rdata = mem[bus_addr];

  mesi_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .core_valid(core_valid), .core_ready(core_ready), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .bus_req_valid(bus_req_valid), .bus_gnt(bus_gnt), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // core request; returns bus ops seen and read data
  task automatic core_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic sh, output int n, output logic [1:0] ops [4],
                         output logic [DW-1:0] rd);
    n = 0; rd = '0;
    for (int k = 0; k < 4; k++) ops[k] = 2'd0;
    @(negedge clk);
    core_valid = 1'b1; core_we = we; core_addr = a; core_wdata = d; bus_shared_in = sh;
    for (int t = 0; t < 20; t++) begin
      #1;
      if (core_ready) begin
        rd = core_rdata;
        if (we) gold[a] = d;
        break;
      end
      if (bus_req_valid && bus_gnt) begin
        if (n < 4) ops[n] = bus_op;
        n++;
        if (bus_op == O_WB) mem[bus_addr] = bus_wdata;
      end
      @(negedge clk);
    end
    @(negedge clk);
    core_valid = 1'b0; bus_shared_in = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a,
                       output logic sh, output logic fl, output logic [DW-1:0] fd);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    #1;
    sh = snp_shared; fl = snp_flush; fd = snp_flush_data;
    if (fl) mem[a] = fd;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [1:0] ops [4];
    logic [DW-1:0] rd, fd;
    logic sh, fl;
    for (int a = 0; a < 64; a++) begin
      mem[a] = 16'h1000 + 16'(a);
      gold[a] = mem[a];
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1;
    chk(!bus_req_valid && !core_ready, "R1 idle outputs", {bus_req_valid, core_ready}, 0);
    for (int a = 0; a < 4; a++) begin
      snoop(O_RD, 6'(a), sh, fl, fd);
      chk(!sh && !fl, "R1 snoop after reset", {sh, fl}, 0);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t e;
      e = VECS[v];
      if (e.kind == K_RD || e.kind == K_WR) begin
        core_op(e.kind == K_WR, e.addr, e.data, e.sh, n, ops, rd);
        chk(n == int'(e.n), $sformatf("vec %0d bus op count", v), n, e.n);
        if (e.n >= 1) chk(ops[0] == e.o0, $sformatf("vec %0d first op", v), ops[0], e.o0);
        if (e.n >= 2) chk(ops[1] == e.o1, $sformatf("vec %0d second op", v), ops[1], e.o1);
        if (e.kind == K_RD)
          chk(rd == gold[e.addr], $sformatf("vec %0d read data", v), rd, gold[e.addr]);
      end else begin
        snoop(e.o0, e.addr, sh, fl, fd);
        chk(sh == e.es, $sformatf("vec %0d snoop shared", v), sh, e.es);
        chk(fl == e.ef, $sformatf("vec %0d snoop flush", v), fl, e.ef);
        if (e.ef) chk(fd == gold[e.addr], $sformatf("vec %0d flush data", v), fd, gold[e.addr]);
        if (e.kind == K_SNPW) begin
          mem[e.addr] = e.data;
          gold[e.addr] = e.data;
        end
      end
    end
    // R9 memory holds the evicted dirty value
    chk(mem[6'h05] == 16'hE005, "R9 victim data in memory", mem[6'h05], 16'hE005);

    // R10 snoop colliding with a pending upgrade
    core_op(1'b0, 6'h08, '0, 1'b1, n, ops, rd);
    chk(n == 1 && rd == gold[6'h08], "R3 fill shared for collision setup", rd, gold[6'h08]);
    gnt_en = 1'b0;
    @(negedge clk);
    core_valid = 1'b1; core_we = 1'b1; core_addr = 6'h08; core_wdata = 16'h7777;
    #1;
    chk(bus_req_valid && bus_op == O_UPG, "R5 pending upgrade", bus_op, O_UPG);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = O_RDX; snp_addr = 6'h08;
    #1;
    chk(!bus_req_valid && !core_ready, "R10 snoop blocks local paths",
        {bus_req_valid, core_ready}, 0);
    chk(!snp_flush && !snp_shared, "R7 shared line no flush", {snp_shared, snp_flush}, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(bus_req_valid && bus_op == O_RDX, "R10 upgrade re-issued as read-exclusive", bus_op, O_RDX);
    gnt_en = 1'b1;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk); #1;
      if (core_ready) break;
    end
    chk(core_ready, "R5 store completes after grant", core_ready, 1);
    @(negedge clk);
    core_valid = 1'b0;
    gold[6'h08] = 16'h7777;
    snoop(O_RD, 6'h08, sh, fl, fd);
    chk(sh && fl && fd == 16'h7777, "R6 modified line flushed on read snoop", fd, 16'h7777);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule